// File: doc/BRIEF.md
# Dual-Sum Byte Stream Frame Receiver

This block sits behind a UART receiver and turns its byte stream into link-layer packets. Each received byte arrives with a one-cycle valid strobe. The parser looks for a two-byte start marker. It then takes a type byte, a length byte and up to `MAX_LEN` payload bytes, followed by two checksum bytes. Two running 8-bit sums are computed over the type, length and payload bytes, and each checksum byte is compared with one of them.

A frame that passes both checks is committed to a set of held outputs: the type, the length, and a payload store that is read through an index port. A one-cycle `pkt_good` pulse marks the commit. A frame that is dropped because its length is too large or a checksum does not match raises a one-cycle `pkt_err` pulse and leaves the held outputs untouched. Bit timing and the meaning of packet contents are handled elsewhere.

Top module: `frame_rx`

## Requirements
- R1: A frame begins with byte 0xBC immediately followed (next valid byte) by byte 0xCF. Any other second byte, including another 0xBC, sends the parser back to looking for 0xBC, and that byte does not start a new frame.
- R2: After the start marker the parser takes, in order, one type byte, one length byte, exactly length payload bytes, checksum byte A and checksum byte B. An accepted frame presents its type on `pkt_type`, its length on `pkt_len`, and payload byte i on `rd_data` when `rd_idx` = i.
- R3: A length byte greater than `MAX_LEN` drops the frame on that byte with a `pkt_err` pulse, and the next byte is treated as hunting for 0xBC. A length equal to `MAX_LEN` is accepted.
- R4: A length of zero goes directly from the length byte to checksum byte A.
- R5: Both sums are first set to the type byte. For the length byte and then each payload byte d: A becomes A+d, then B becomes B+A (new A). All arithmetic is modulo 256. Byte A must equal A and byte B must equal B.
- R6: When checksum byte A does not match, the frame is dropped on that byte with a `pkt_err` pulse, and the very next byte is taken as a possible 0xBC.
- R7: When checksum byte B does not match, `pkt_err` pulses and the held outputs keep their previous values. After byte B the parser always returns to hunting.
- R8: `pkt_good` is high for exactly one clock, in the cycle after the edge that takes a matching byte B. `pkt_type`, `pkt_len` and the payload store change only at that edge.
- R9: A synchronous active-high reset puts the parser in hunting and clears `pkt_type`, `pkt_len`, the payload store, `pkt_good` and `pkt_err`.
- R10: A byte presented while `byte_vld` is low has no effect on parsing.
- R11: `pkt_good` and `pkt_err` are never high together, and each pulse lasts one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Strobe: `byte_in` holds a received byte |
| byte_in | input | 8 | Received byte |
| rd_idx | input | $clog2(MAX_LEN) | Payload read index |
| rd_data | output | 8 | Payload byte at `rd_idx` of the last accepted frame |
| pkt_type | output | 8 | Type byte of the last accepted frame |
| pkt_len | output | $clog2(MAX_LEN+1) | Length of the last accepted frame |
| pkt_good | output | 1 | One-cycle pulse per accepted frame |
| pkt_err | output | 1 | One-cycle pulse per dropped frame |

## Verification
The bench builds the block with the default `MAX_LEN` of 32. With that value, lengths of 0, 1, a middle value, exactly 32 and 33 can all be sent within a short run, so both the full-store boundary and the one-past-limit abort are covered. The 8-bit sums wrap many times over a 32-byte payload of large values, which tests the modulo behaviour. Frames are sent with idle gaps that carry 0xBC on the data lines while the strobe is low, and sometimes back to back with no gap, so that the immediate-drop rule on byte A is checked against a new start marker.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

    localparam logic [7:0] MARK_FIRST  = 8'hBC;
    localparam logic [7:0] MARK_SECOND = 8'hCF;

    typedef enum logic [2:0] {
        ST_HUNT1,
        ST_HUNT2,
        ST_TYPE,
        ST_LEN,
        ST_DATA,
        ST_CKA,
        ST_CKB
    } rx_state_e;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
    } sum_pair_t;

    typedef struct packed {
        logic load;    // seed both sums with the type byte
        logic acc;     // fold a length or payload byte into the sums
        logic wr;      // store a payload byte
        logic commit;  // frame accepted
        logic drop;    // frame rejected
    } rx_evt_t;

    function automatic sum_pair_t sum_step(sum_pair_t s, logic [7:0] d);
        sum_pair_t r;
        r.a = s.a + d;
        r.b = s.b + r.a;
        return r;
    endfunction

endpackage

// File: rtl/frx_sums.sv
module frx_sums
    import frame_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       acc,
    input  logic [7:0] din,
    output sum_pair_t  sums
);
    sum_pair_t sums_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sums_q <= '0;
        end else if (load) begin
            sums_q.a <= din;
            sums_q.b <= din;
        end else if (acc) begin
            sums_q <= sum_step(sums_q, din);
        end
    end

    assign sums = sums_q;
endmodule

// File: rtl/frx_fsm.sv
module frx_fsm
    import frame_rx_pkg::*;
#(
    parameter int MAX_LEN = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld,
    input  logic [7:0]           din,
    input  sum_pair_t            sums,
    output rx_evt_t              evt,
    output logic [$clog2(MAX_LEN)-1:0]   idx,
    output logic [$clog2(MAX_LEN+1)-1:0] len_q,
    output logic [7:0]           type_q
);
    localparam int LEN_W = $clog2(MAX_LEN + 1);
    localparam int IDX_W = $clog2(MAX_LEN);
    localparam logic [7:0] MAX_B = 8'(MAX_LEN);

    rx_state_e st, st_nx;
    logic      last_data;

    assign last_data = (LEN_W'(idx) + LEN_W'(1)) == len_q;

    always_comb begin
        st_nx = st;
        evt   = '0;
        if (vld) begin
            unique case (st)
                ST_HUNT1: if (din == MARK_FIRST) st_nx = ST_HUNT2;
                ST_HUNT2: st_nx = (din == MARK_SECOND) ? ST_TYPE : ST_HUNT1;
                ST_TYPE: begin
                    evt.load = 1'b1;
                    st_nx    = ST_LEN;
                end
                ST_LEN: begin
                    if (din > MAX_B) begin
                        evt.drop = 1'b1;
                        st_nx    = ST_HUNT1;
                    end else begin
                        evt.acc = 1'b1;
                        st_nx   = (din == 8'd0) ? ST_CKA : ST_DATA;
                    end
                end
                ST_DATA: begin
                    evt.acc = 1'b1;
                    evt.wr  = 1'b1;
                    if (last_data) st_nx = ST_CKA;
                end
                ST_CKA: begin
                    if (din == sums.a) begin
                        st_nx = ST_CKB;
                    end else begin
                        evt.drop = 1'b1;
                        st_nx    = ST_HUNT1;
                    end
                end
                ST_CKB: begin
                    evt.commit = (din == sums.b);
                    evt.drop   = (din != sums.b);
                    st_nx      = ST_HUNT1;
                end
                default: st_nx = ST_HUNT1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_HUNT1;
            idx    <= '0;
            len_q  <= '0;
            type_q <= '0;
        end else begin
            st <= st_nx;
            if (evt.load) type_q <= din;
            if (vld && st == ST_LEN) begin
                len_q <= din[LEN_W-1:0];
                idx   <= '0;
            end else if (evt.wr) begin
                idx <= idx + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/frx_store.sv
module frx_store #(
    parameter int MAX_LEN = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr,
    input  logic [$clog2(MAX_LEN)-1:0] wr_idx,
    input  logic [7:0]                 wr_data,
    input  logic                       commit,
    input  logic [$clog2(MAX_LEN)-1:0] rd_idx,
    output logic [7:0]                 rd_data
);
    logic [7:0] work [MAX_LEN];
    logic [7:0] held [MAX_LEN];

    for (genvar i = 0; i < MAX_LEN; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                work[i] <= '0;
                held[i] <= '0;
            end else begin
                if (wr && int'(wr_idx) == i) work[i] <= wr_data;
                if (commit) held[i] <= work[i];
            end
        end
    end

    assign rd_data = (int'(rd_idx) < MAX_LEN) ? held[rd_idx] : 8'd0;
endmodule

// File: rtl/frame_rx.sv
module frame_rx
    import frame_rx_pkg::*;
#(
    parameter int MAX_LEN = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         byte_vld,
    input  logic [7:0]                   byte_in,
    input  logic [$clog2(MAX_LEN)-1:0]   rd_idx,
    output logic [7:0]                   rd_data,
    output logic [7:0]                   pkt_type,
    output logic [$clog2(MAX_LEN+1)-1:0] pkt_len,
    output logic                         pkt_good,
    output logic                         pkt_err
);
    localparam int LEN_W = $clog2(MAX_LEN + 1);
    localparam int IDX_W = $clog2(MAX_LEN);

    sum_pair_t        sums;
    rx_evt_t          evt;
    logic [IDX_W-1:0] idx;
    logic [LEN_W-1:0] len_q;
    logic [7:0]       type_q;

    frx_sums u_sums (
        .clk  (clk),
        .rst  (rst),
        .load (evt.load),
        .acc  (evt.acc),
        .din  (byte_in),
        .sums (sums)
    );

    frx_fsm #(.MAX_LEN(MAX_LEN)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .vld    (byte_vld),
        .din    (byte_in),
        .sums   (sums),
        .evt    (evt),
        .idx    (idx),
        .len_q  (len_q),
        .type_q (type_q)
    );

    frx_store #(.MAX_LEN(MAX_LEN)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr      (evt.wr),
        .wr_idx  (idx),
        .wr_data (byte_in),
        .commit  (evt.commit),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_type <= '0;
            pkt_len  <= '0;
            pkt_good <= 1'b0;
            pkt_err  <= 1'b0;
        end else begin
            pkt_good <= evt.commit;
            pkt_err  <= evt.drop;
            if (evt.commit) begin
                pkt_type <= type_q;
                pkt_len  <= len_q;
            end
        end
    end
endmodule

// File: rtl/frame_rx_chk.sv
module frame_rx_chk #(
    parameter int MAX_LEN = 32
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         byte_vld,
    input logic [$clog2(MAX_LEN+1)-1:0] pkt_len,
    input logic [7:0]                   pkt_type,
    input logic                         pkt_good,
    input logic                         pkt_err
);
    AST_GOOD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) pkt_good |=> !pkt_good); // R8
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) pkt_err |=> !pkt_err); // R11
    AST_NO_BOTH_PULSES: assert property (@(posedge clk) disable iff (rst) !(pkt_good && pkt_err)); // R11
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst) !pkt_good |-> ($stable(pkt_type) && $stable(pkt_len))); // R8
    AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (rst) int'(pkt_len) <= MAX_LEN); // R3
    AST_GOOD_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst) pkt_good |-> $past(byte_vld)); // R10
    AST_ERR_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst) pkt_err |-> $past(byte_vld)); // R10
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (!pkt_good && !pkt_err)); // R9
endmodule

bind frame_rx frame_rx_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .byte_vld (byte_vld),
    .pkt_len  (pkt_len),
    .pkt_type (pkt_type),
    .pkt_good (pkt_good),
    .pkt_err  (pkt_err)
);

// File: tb/tb_frame_rx.sv
module tb_frame_rx;
    localparam int MAX_LEN = 32;
    localparam int LEN_W = $clog2(MAX_LEN + 1);
    localparam int IDX_W = $clog2(MAX_LEN);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             byte_vld = 1'b0;
    logic [7:0]       byte_in = 8'h00;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [7:0]       rd_data;
    logic [7:0]       pkt_type;
    logic [LEN_W-1:0] pkt_len;
    logic             pkt_good;
    logic             pkt_err;

    int n_checks = 0;
    int n_fail   = 0;
    int n_good   = 0;
    int n_err    = 0;
    int gap      = 1;

    logic [7:0] pl [64];
    logic [7:0] exp_pl [MAX_LEN];
    logic [7:0] exp_type = 8'h00;
    int         exp_len  = 0;

    always #2 clk = ~clk;

    frame_rx #(.MAX_LEN(MAX_LEN)) dut (
        .clk      (clk),
        .rst      (rst),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .pkt_type (pkt_type),
        .pkt_len  (pkt_len),
        .pkt_good (pkt_good),
        .pkt_err  (pkt_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (pkt_good) n_good++;
            if (pkt_err) n_err++;
        end
    end

    task automatic check_eq(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_byte(logic [7:0] b);
        @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = b;
        @(negedge clk);
        byte_vld = 1'b0;
        byte_in  = 8'hBC;  // R10: a marker value while the strobe is low
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // compare held outputs with the bench's own record of the last accepted frame
    task automatic check_held(string req);
        check_eq({req, " type"}, int'(pkt_type), int'(exp_type));
        check_eq({req, " len"}, int'(pkt_len), exp_len);
        for (int i = 0; i < MAX_LEN; i++) begin
            rd_idx = IDX_W'(i);
            #1;
            if (rd_data != exp_pl[i]) begin
                check_eq({req, " payload"}, int'(rd_data), int'(exp_pl[i]));
            end
        end
        n_checks++;
    endtask

    // mode: 0 clean, 1 bad byte A (B not sent), 2 bad byte B
    task automatic send_frame(string req, logic [7:0] t, int len, int mode);
        logic [7:0] a;
        logic [7:0] b;
        int g0;
        int e0;
        g0 = n_good;
        e0 = n_err;
        a = t;
        b = t;
        a = a + 8'(len);
        b = b + a;
        for (int i = 0; i < len; i++) begin
            a = a + pl[i];
            b = b + a;
        end
        send_byte(8'hBC);
        send_byte(8'hCF);
        send_byte(t);
        send_byte(8'(len));
        for (int i = 0; i < len; i++) send_byte(pl[i]);
        if (mode == 1) begin
            send_byte(a ^ 8'h01);
        end else begin
            send_byte(a);
            send_byte(mode == 2 ? b + 8'd1 : b);
        end
        idle(2);
        if (mode == 0) begin
            exp_type = t;
            exp_len  = len;
            for (int i = 0; i < len; i++) exp_pl[i] = pl[i];
        end
        check_eq({req, " good pulses"}, n_good - g0, mode == 0 ? 1 : 0);
        check_eq({req, " err pulses"}, n_err - e0, mode == 0 ? 0 : 1);
        check_held(req);
    endtask

    task automatic t_reset;
        check_eq("R9 reset good", int'(pkt_good), 0);
        check_eq("R9 reset err", int'(pkt_err), 0);
        check_held("R9 reset outputs");
    endtask

    task automatic t_basic;
        for (int i = 0; i < 5; i++) pl[i] = 8'(8'h11 * (i + 1));
        send_frame("R2 R5 basic len5", 8'h00, 5, 0);
        gap = 3;
        for (int i = 0; i < 3; i++) pl[i] = 8'(8'hF0 + i);
        send_frame("R10 R5 gapped len3", 8'h42, 3, 0);
        gap = 1;
    endtask

    task automatic t_zero_len;
        send_frame("R4 zero length", 8'h7E, 0, 0);
    endtask

    task automatic t_max_len;
        for (int i = 0; i < MAX_LEN; i++) pl[i] = 8'(8'hFF - 3 * i);
        send_frame("R3 R5 full length", 8'hE5, MAX_LEN, 0);
    endtask

    task automatic t_over_len;
        int e0;
        int g0;
        e0 = n_err;
        g0 = n_good;
        send_byte(8'hBC);
        send_byte(8'hCF);
        send_byte(8'h01);
        send_byte(8'(MAX_LEN + 1));
        idle(2);
        check_eq("R3 over length err", n_err - e0, 1);
        // the frame is gone: a clean frame right after must be accepted
        pl[0] = 8'h99;
        send_frame("R3 after abort", 8'h05, 1, 0);
        check_eq("R3 over length no good", n_good - g0, 1);
    endtask

    task automatic t_bad_a;
        for (int i = 0; i < 2; i++) pl[i] = 8'(8'h30 + i);
        send_frame("R6 bad A", 8'h21, 2, 1);
        // next frame follows with no byte B in between
        send_frame("R6 restart right after A", 8'h22, 2, 0);
    endtask

    task automatic t_bad_b;
        for (int i = 0; i < 4; i++) pl[i] = 8'(8'hA0 + i);
        send_frame("R7 bad B", 8'h33, 4, 2);
        send_frame("R7 hunting after B", 8'h34, 4, 0);
    endtask

    task automatic t_marker;
        int g0;
        int e0;
        g0 = n_good;
        e0 = n_err;
        // BC BC CF: the second BC is a mismatch, CF then does not count
        send_byte(8'hBC);
        send_byte(8'hBC);
        send_byte(8'hCF);
        send_byte(8'h10);
        send_byte(8'h00);
        send_byte(8'h10);
        send_byte(8'h10);
        idle(2);
        check_eq("R1 double marker good", n_good - g0, 0);
        check_eq("R1 double marker err", n_err - e0, 0);
        check_held("R1 double marker held");
        // BC then a wrong byte
        send_byte(8'hBC);
        send_byte(8'h00);
        send_frame("R1 after bad second", 8'h44, 0, 0);
    endtask

    task automatic t_vld_low;
        int g0;
        g0 = n_good;
        @(negedge clk);
        byte_vld = 1'b0;
        for (int i = 0; i < 8; i++) begin
            byte_in = (i % 2 == 0) ? 8'hBC : 8'hCF;
            @(negedge clk);
        end
        check_eq("R10 strobe low no pulse", n_good - g0, 0);
        check_held("R10 strobe low held");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < MAX_LEN; i++) exp_pl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero_len();
        t_max_len();
        t_over_len();
        t_bad_a();
        t_bad_b();
        t_marker();
        t_vld_low();
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end
endmodule